// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block is the serial programming port of a dual-loop frequency synthesizer. A host drives three wires: a serial clock, a data line and a load strobe. The block samples all three into the system clock domain. On every rising edge of the serial clock it shifts one data bit into a 22-bit word, most significant bit first. On the rising edge of the load strobe it copies that word into one of four configuration latches. The two bits shifted in last choose the latch.

Two latches hold reference-divider settings, one for the IF loop and one for the RF loop. Each holds a 15-bit divide value and five mode bits. The other two latches hold the main-divider settings: the swallow count A, the programmable count B, a prescaler-modulus select and a powerdown bit. The latched fields drive the rest of the synthesizer as plain outputs. Loading never depends on the powerdown bits, so a powered-down loop can always be reprogrammed.

Top module: `ser_cfg_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, every latched output is zero until the first load.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into a 22-bit word, most significant bit first. Word bit 21 is the first bit shifted and bit 0 the last. The word holds its value between edges.
- R3: A rising edge of `ser_le` loads word bits [21:2] into exactly one latch, chosen by word bits [1:0]: 00 IF reference, 01 RF reference, 10 IF divider, 11 RF divider. The other three latches keep their contents.
- R4: Latched outputs change only on a rising edge of `ser_le`. Shifting with the strobe low has no effect on them, and so does shifting while the strobe is held high after its rising edge.
- R5: A reference latch maps the divide value to word bits [16:2] (bit 2 is the LSB) and the mode field to bits [21:17]. Mode bit 0 (word bit 17) is phase-detector polarity, 1 is charge-pump current select, 2 is charge-pump tri-state, 3 is lock-detect select and 4 is Fo select.
- R6: A divider latch maps A to word bits [8:2], B to bits [19:9], prescaler select to bit 20 and powerdown to bit 21.
- R7: For the IF divider latch only word bits [5:2] reach A. Word bits [8:6] are ignored, and the upper three bits of `ifn_a` always read zero.
- R8: A load does not clear the shift word. A strobe after fewer than 22 new shifts latches the retained bits joined with the new ones, and a strobe with no shifts latches the same word again.
- R9: Frames load into every latch while either or both powerdown bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, rising edge loads |
| ifr_div | output | 15 | IF reference divide value |
| ifr_mode | output | 5 | IF reference mode bits |
| rfr_div | output | 15 | RF reference divide value |
| rfr_mode | output | 5 | RF reference mode bits |
| ifn_a | output | 7 | IF swallow count (upper 3 bits zero) |
| ifn_b | output | 11 | IF programmable count |
| ifn_pre | output | 1 | IF prescaler modulus select |
| ifn_pwdn | output | 1 | IF powerdown |
| rfn_a | output | 7 | RF swallow count |
| rfn_b | output | 11 | RF programmable count |
| rfn_pre | output | 1 | RF prescaler modulus select |
| rfn_pwdn | output | 1 | RF powerdown |

## Verification
A table of full frames visits all four addresses. Its payloads are asymmetric, all-ones and all-zeros, so a swapped or shifted field, a wrong latch, or bit-order reversal shows up as a mismatch in a specific output. IF divider frames set the ignored A bits to expose a missing mask. Directed sequences shift without a strobe, shift with the strobe held high, send a two-bit frame after a full one, and repeat a strobe with no shifts, which separates retained-word behaviour from a word cleared on load. Frames sent with both powerdown bits set confirm that loading does not depend on them.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   typedef enum logic [1:0] {
      SEL_IF_REF = 2'b00,
      SEL_RF_REF = 2'b01,
      SEL_IF_DIV = 2'b10,
      SEL_RF_DIV = 2'b11
   } latch_sel_e;

   localparam int SEL_W   = 2;
   localparam int N_LATCH = 4;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] level_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgld_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage[s] <= '0;
      end else begin
         stage[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      end
   end

   assign level_o = stage[STAGES-1];
endmodule

// File: rtl/cfgld_rise.sv
module cfgld_rise #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= level_i;
   end

   assign rise_o = level_i & ~prev;
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
   parameter int W = 22
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_i,
   output logic [W-1:0] word_o
);
   if (W < 3) begin : g_bad_w
      $error("cfgld_shifter: W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_o <= '0;
      else if (shift_en) word_o <= {word_o[W-2:0], bit_i};
   end
endmodule

// File: rtl/cfgld_bank.sv
module cfgld_bank #(
   parameter int PAY_W   = 20,
   parameter int N_LATCH = 4,
   parameter int SEL_W   = 2,
   parameter logic [N_LATCH-1:0][PAY_W-1:0] KEEP = '1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load_i,
   input  logic [SEL_W-1:0]                  sel_i,
   input  logic [PAY_W-1:0]                  pay_i,
   output logic [N_LATCH-1:0][PAY_W-1:0]     bank_o
);
   if (N_LATCH > (1 << SEL_W)) begin : g_bad_sel
      $error("cfgld_bank: SEL_W cannot address N_LATCH latches");
   end

   for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
      logic hit;
      assign hit = load_i && (sel_i == SEL_W'(g));

      if (KEEP[g] == {PAY_W{1'b1}}) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bank_o[g] <= '0;
            else if (hit) bank_o[g] <= pay_i;
         end
      end else begin : g_masked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bank_o[g] <= '0;
            else if (hit) bank_o[g] <= pay_i & KEEP[g];
         end
      end
   end
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader #(
   parameter int R_W         = 15,
   parameter int MODE_W      = 5,
   parameter int A_W         = 7,
   parameter int IF_A_W      = 4,
   parameter int B_W         = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [R_W-1:0]    ifr_div,
   output logic [MODE_W-1:0] ifr_mode,
   output logic [R_W-1:0]    rfr_div,
   output logic [MODE_W-1:0] rfr_mode,
   output logic [A_W-1:0]    ifn_a,
   output logic [B_W-1:0]    ifn_b,
   output logic              ifn_pre,
   output logic              ifn_pwdn,
   output logic [A_W-1:0]    rfn_a,
   output logic [B_W-1:0]    rfn_b,
   output logic              rfn_pre,
   output logic              rfn_pwdn
);
   import cfgld_pkg::*;

   localparam int REF_PAY = R_W + MODE_W;
   localparam int DIV_PAY = A_W + B_W + 2;
   localparam int PAY_W   = REF_PAY;
   localparam int FRAME_W = PAY_W + SEL_W;
   localparam int PRE_BIT = A_W + B_W;
   localparam int PWD_BIT = A_W + B_W + 1;

   localparam logic [PAY_W-1:0] ALL_ONES = '1;
   localparam logic [PAY_W-1:0] IFN_DROP =
      ((PAY_W'(1) << (A_W - IF_A_W)) - PAY_W'(1)) << IF_A_W;
   localparam logic [N_LATCH-1:0][PAY_W-1:0] KEEP =
      {ALL_ONES, ~IFN_DROP, ALL_ONES, ALL_ONES};

   if (REF_PAY != DIV_PAY) begin : g_bad_layout
      $error("ser_cfg_loader: reference and divider payloads differ in width");
   end
   if (IF_A_W > A_W) begin : g_bad_ifa
      $error("ser_cfg_loader: IF_A_W exceeds A_W");
   end

   // synchronize {le, data, clk}; data shares the latency of the strobes
   logic [2:0] lvl;
   logic [1:0] rise;
   logic       sclk_rise, le_rise, data_lvl;

   cfgld_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_le, ser_data, ser_clk}),
      .level_o (lvl)
   );

   cfgld_rise #(.WIDTH(2)) u_rise (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i ({lvl[2], lvl[0]}),
      .rise_o  (rise)
   );

   assign sclk_rise = rise[0];
   assign le_rise   = rise[1];
   assign data_lvl  = lvl[1];

   logic [FRAME_W-1:0] sr_word;

   cfgld_shifter #(.W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sclk_rise),
      .bit_i    (data_lvl),
      .word_o   (sr_word)
   );

   logic [N_LATCH-1:0][PAY_W-1:0] bank;

   cfgld_bank #(
      .PAY_W   (PAY_W),
      .N_LATCH (N_LATCH),
      .SEL_W   (SEL_W),
      .KEEP    (KEEP)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (le_rise),
      .sel_i  (sr_word[SEL_W-1:0]),
      .pay_i  (sr_word[FRAME_W-1:SEL_W]),
      .bank_o (bank)
   );

   // field decode
   assign ifr_div  = bank[SEL_IF_REF][R_W-1:0];
   assign ifr_mode = bank[SEL_IF_REF][PAY_W-1:R_W];
   assign rfr_div  = bank[SEL_RF_REF][R_W-1:0];
   assign rfr_mode = bank[SEL_RF_REF][PAY_W-1:R_W];

   assign ifn_a    = bank[SEL_IF_DIV][A_W-1:0];
   assign ifn_b    = bank[SEL_IF_DIV][A_W+B_W-1:A_W];
   assign ifn_pre  = bank[SEL_IF_DIV][PRE_BIT];
   assign ifn_pwdn = bank[SEL_IF_DIV][PWD_BIT];
   assign rfn_a    = bank[SEL_RF_DIV][A_W-1:0];
   assign rfn_b    = bank[SEL_RF_DIV][A_W+B_W-1:A_W];
   assign rfn_pre  = bank[SEL_RF_DIV][PRE_BIT];
   assign rfn_pwdn = bank[SEL_RF_DIV][PWD_BIT];
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int PAY_W   = 20,
   parameter int FRAME_W = 22
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sclk_rise,
   input logic                    le_rise,
   input logic                    data_lvl,
   input logic [FRAME_W-1:0]      sr_word,
   input logic [3:0][PAY_W-1:0]   bank
);
   // R1: latches read zero while reset is held
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (bank == '0));

   // R2: one bit enters at the bottom per serial clock edge
   p_shift_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (sr_word == {$past(sr_word[FRAME_W-2:0]), $past(data_lvl)}));

   // R2: word holds between serial clock edges
   p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(sr_word));

   // R4: no strobe edge, no latch change
   p_hold_without_le_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable(bank));

   // R3: a strobe changes at most one latch
   p_single_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise |=> ($countones({bank[3] != $past(bank[3]),
                               bank[2] != $past(bank[2]),
                               bank[1] != $past(bank[1]),
                               bank[0] != $past(bank[0])}) <= 1));

   // R3: unmasked latches receive the payload addressed by the last two bits
   p_load_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && sr_word[1:0] != 2'b10) |=>
         (bank[$past(sr_word[1:0])] == $past(sr_word[FRAME_W-1:2])));
endmodule

bind ser_cfg_loader cfgld_chk #(.PAY_W(PAY_W), .FRAME_W(FRAME_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk_rise (sclk_rise),
   .le_rise   (le_rise),
   .data_lvl  (data_lvl),
   .sr_word   (sr_word),
   .bank      (bank)
);

// File: tb/sim_ser_cfg_loader.sv
`timescale 1ns/1ps
module sim_ser_cfg_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [14:0] ifr_div, rfr_div;
   logic [4:0]  ifr_mode, rfr_mode;
   logic [6:0]  ifn_a, rfn_a;
   logic [10:0] ifn_b, rfn_b;
   logic        ifn_pre, ifn_pwdn, rfn_pre, rfn_pwdn;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [19:0] exp_pay [4];
   logic [21:0] mdl_sr;

   always #2 clk = ~clk;   // 250 MHz

   ser_cfg_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .ifr_div(ifr_div), .ifr_mode(ifr_mode), .rfr_div(rfr_div), .rfr_mode(rfr_mode),
      .ifn_a(ifn_a), .ifn_b(ifn_b), .ifn_pre(ifn_pre), .ifn_pwdn(ifn_pwdn),
      .rfn_a(rfn_a), .rfn_b(rfn_b), .rfn_pre(rfn_pre), .rfn_pwdn(rfn_pwdn)
   );

   // full frames: {payload, address}
   localparam logic [21:0] VEC [10] = '{
      {20'h4A5C3, 2'b00}, {20'hB1234, 2'b01}, {20'h7FFFF, 2'b10}, {20'h80001, 2'b11},
      {20'hFFFFF, 2'b00}, {20'h00000, 2'b01}, {20'h5A5A5, 2'b11}, {20'hC0E71, 2'b10},
      {20'hAAAAA, 2'b01}, {20'h12345, 2'b10}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      check({ctx, " R5 ifr_div"},  32'(ifr_div),  32'(exp_pay[0][14:0]));
      check({ctx, " R5 ifr_mode"}, 32'(ifr_mode), 32'(exp_pay[0][19:15]));
      check({ctx, " R5 rfr_div"},  32'(rfr_div),  32'(exp_pay[1][14:0]));
      check({ctx, " R5 rfr_mode"}, 32'(rfr_mode), 32'(exp_pay[1][19:15]));
      check({ctx, " R7 ifn_a"},    32'(ifn_a),    32'({3'b000, exp_pay[2][3:0]}));
      check({ctx, " R6 ifn_b"},    32'(ifn_b),    32'(exp_pay[2][17:7]));
      check({ctx, " R6 ifn_pre"},  32'(ifn_pre),  32'(exp_pay[2][18]));
      check({ctx, " R6 ifn_pwdn"}, 32'(ifn_pwdn), 32'(exp_pay[2][19]));
      check({ctx, " R6 rfn_a"},    32'(rfn_a),    32'(exp_pay[3][6:0]));
      check({ctx, " R6 rfn_b"},    32'(rfn_b),    32'(exp_pay[3][17:7]));
      check({ctx, " R6 rfn_pre"},  32'(rfn_pre),  32'(exp_pay[3][18]));
      check({ctx, " R6 rfn_pwdn"}, 32'(rfn_pwdn), 32'(exp_pay[3][19]));
   endtask

   task automatic shift_bits(input logic [21:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = w[i];
         #32 ser_clk = 1'b1;
         mdl_sr = {mdl_sr[20:0], w[i]};
         #32 ser_clk = 1'b0;
      end
      #32;
   endtask

   task automatic le_up();
      ser_le = 1'b1;
      exp_pay[mdl_sr[1:0]] = mdl_sr[21:2];
      #64;
   endtask

   task automatic le_down();
      ser_le = 1'b0;
      #64;
   endtask

   task automatic send(input logic [21:0] w);
      shift_bits(w, 22);
      le_up();
      le_down();
   endtask

   initial begin
      #400_000;
      if (!done) begin
         errors++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 4; k++) exp_pay[k] = '0;
      mdl_sr = '0;
      #1 rst_n = 1'b0;
      #40;
      check_all("R1 in-reset");
      rst_n = 1'b1;
      #64;
      check_all("R1 after-reset");

      // table walk: every address, several payload patterns (R2, R3)
      for (int v = 0; v < 10; v++) begin
         send(VEC[v]);
         check_all($sformatf("R2 R3 vec%0d", v));
      end

      // R4: shifting without a strobe leaves all latches alone
      shift_bits({20'h33333, 2'b11}, 22);
      check_all("R4 no-strobe");
      le_up();
      check_all("R4 strobe-rise");
      // R4: strobe held high while a new frame is shifted
      shift_bits({20'h0F0F0, 2'b00}, 22);
      exp_pay[0] = exp_pay[0];
      check_all("R4 strobe-held");
      le_down();
      le_up();
      le_down();
      check_all("R4 second-rise");

      // R8: short frame after a full one reuses retained bits
      shift_bits(22'b01, 2);
      le_up();
      le_down();
      check_all("R8 short-frame");
      check("R8 rfr_div retained", 32'(rfr_div), 32'({20'h0F0F0, 2'b00} >> 0) & 32'h7FFF);
      // R8: strobe with no shifts reloads the same word
      le_up();
      le_down();
      check_all("R8 no-shift-strobe");

      // R9: both loops powered down, loading still works everywhere
      send({1'b1, 1'b1, 11'd300, 7'd9, 2'b11});
      send({1'b1, 1'b0, 11'd77, 7'd5, 2'b10});
      check("R9 rfn_pwdn set", 32'(rfn_pwdn), 32'd1);
      check("R9 ifn_pwdn set", 32'(ifn_pwdn), 32'd1);
      send({5'b01011, 15'd1234, 2'b01});
      send({5'b10100, 15'd3, 2'b00});
      send({1'b1, 1'b0, 11'd2047, 7'd127, 2'b11});
      check_all("R9 powered-down loads");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule